// File: doc/BRIEF.md
# Flash Command-Set Identification Engine

This block finds out, after reset, which of two flash command sets the parts on the boot flash bus use. When `start` is pulsed it goes through a fixed table of candidate device types, lowest entry first. For each candidate it performs that candidate's identify write sequence. It then reads the identification bytes back and compares them, one byte at a time, against the values that candidate expects. The first candidate whose bytes all match is taken as the fitted type.

Once a type is chosen, the engine brings every part in the 1 MB flash window back to a known state. It steps through the part base addresses, one chip size apart. At each base it sends the chosen type's clear-status sequence and then its return-to-array-read sequence. After that it raises `type_valid` along with the latched `type_code`, and both stay unchanged until the next `start`. If no candidate matches, it raises `probe_err` and leaves `type_valid` low. Every command write is followed by a programmable settling wait of `WAIT_CYCLES` clock cycles.

The FSM has five states. S_IDLE goes to S_CMD_WR when `start` is seen. S_CMD_WR always goes to S_CMD_WAIT. When the wait expires, S_CMD_WAIT goes to one of four places:
- back to S_CMD_WR for the next write of the same sequence;
- to S_RSP_RD once an identify sequence is complete;
- to S_CMD_WR for the next sequence or the next part during re-initialisation;
- to S_IDLE after the last part has been re-initialised.

S_RSP_RD always goes to S_RSP_CMP. From S_RSP_CMP the engine goes to one of four places:
- S_RSP_RD for the next byte;
- S_CMD_WR to begin re-initialisation when the final byte matches;
- S_CMD_WR with the next candidate on a mismatch;
- S_IDLE with the error flag when the last candidate fails.

Top module: `flash_probe`

## Requirements
- R1: After reset, `busy`, `type_valid`, `probe_err`, `fl_we` and `fl_re` are low. A `start` pulse seen while idle raises `busy` on the following cycle. A `start` pulse seen while `busy` is high has no effect on the bus sequence or the result.
- R2: Candidates are tried in ascending order, and the first candidate whose response bytes all match is reported as `type_code`. Code 0 is the single-write set and code 1 is the unlock-sequence set. When a part would answer both, the result is code 0.
- R3: The identify sequence for candidate 0 is a single write of 0x90 to address 0x00000. A match requires reading 0x89 at address 0x00000 and 0xA2 at address 0x00001.
- R4: The identify sequence for candidate 1 is three writes: 0xAA to 0x05555, then 0x55 to 0x02AAA, then 0x90 to 0x05555. A match requires reading 0x01 at address 0x00000 and 0x20 at address 0x00001.
- R5: After every command write, the next bus access (write or read) takes place exactly `WAIT_CYCLES`+1 cycles after that write.
- R6: Response bytes are compared in address order. The first mismatching byte ends the comparison, so no more response reads are made for that candidate, and the next candidate's identify sequence begins.
- R7: After a match, every part base in the 1 MB window (base k × chip size, where chip size is 1 MB for code 0 and 128 KB for code 1) receives the clear-status sequence and then the array-read sequence, in ascending base order.
  - For code 0 the clear-status sequence is 0x50 at the base and the array-read sequence is 0xFF at the base.
  - For code 1 both sequences are 0xAA at base+0x5555, 0x55 at base+0x2AAA and 0xF0 at base+0x5555.
- R8: If no candidate matches, `probe_err` rises when `busy` falls, and `type_valid` stays low. `type_valid` and `probe_err` are never high together.
- R9: `type_valid` rises when `busy` falls after re-initialisation finishes. It holds, with `type_code` stable, until the next accepted `start`, which clears both `type_valid` and `probe_err`.
- R10: Read data on `fl_rdata` is taken in the cycle after the cycle in which `fl_re` is high.
- R11: `fl_we` and `fl_re` are single-cycle strobes. They are never high in the same cycle, and they are only high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a probe |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | 20 | Flash byte address for the current strobe |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, valid the cycle after `fl_re` |
| busy | output | 1 | High while a probe is running |
| type_valid | output | 1 | High when `type_code` holds an identified type |
| type_code | output | 1 | Identified command-set code |
| probe_err | output | 1 | High when no candidate matched |

## Verification
The signals become due at different times, and the bench samples each one on the falling edge of the cycle in which it is due.

| Signal or event | When it is due | How the bench checks it |
|---|---|---|
| `busy` (and cleared flags) | The cycle after `start` | Checked on the next falling edge |
| `fl_rdata` | The cycle after the `fl_re` that requested it | The bench's flash model registers it on that rising edge |
| Next bus strobe after a write | Exactly `WAIT_CYCLES`+1 cycles after the write | Measured in cycles counted at each rising edge |
| `type_valid`, `type_code`, `probe_err` | On the falling edge after `busy` drops | Checked there, then checked again after a random idle gap to confirm they held |

Alongside these checks, the bench builds the expected write and read lists from the requirements. It compares them entry by entry against the strobes it logged.

// File: rtl/fprb_pkg.sv
package fprb_pkg;

    localparam int NUM_CAND       = 2;
    localparam int CAND_W         = 1;
    localparam int WIN_SHIFT      = 20;
    localparam int ADDR_W         = WIN_SHIFT;
    localparam int MIN_CHIP_SHIFT = 17;
    localparam int MAX_CHIPS      = 1 << (WIN_SHIFT - MIN_CHIP_SHIFT);
    localparam int CHIP_W         = $clog2(MAX_CHIPS);
    localparam int IDX_W          = 2;
    localparam int RSP_LEN        = 2;
    localparam int RIDX_W         = $clog2(RSP_LEN);

    typedef enum logic [1:0] {
        SEQ_ID  = 2'd0,
        SEQ_RST = 2'd1,
        SEQ_RD  = 2'd2
    } seq_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } bus_op_t;

    function automatic logic [IDX_W-1:0] cmd_last_idx(input logic [CAND_W-1:0] cand);
        return (cand == CAND_W'(1)) ? IDX_W'(2) : IDX_W'(0);
    endfunction

    function automatic bus_op_t cmd_op(input logic [CAND_W-1:0] cand,
                                       input seq_e seq,
                                       input logic [IDX_W-1:0] idx);
        bus_op_t op;
        op.addr = '0;
        op.data = 8'hFF;
        if (cand == CAND_W'(0)) begin
            case (seq)
                SEQ_ID:  op.data = 8'h90;
                SEQ_RST: op.data = 8'h50;
                default: op.data = 8'hFF;
            endcase
        end else begin
            case (idx)
                IDX_W'(0): begin op.addr = ADDR_W'(20'h05555); op.data = 8'hAA; end
                IDX_W'(1): begin op.addr = ADDR_W'(20'h02AAA); op.data = 8'h55; end
                default: begin
                    op.addr = ADDR_W'(20'h05555);
                    op.data = (seq == SEQ_ID) ? 8'h90 : 8'hF0;
                end
            endcase
        end
        return op;
    endfunction

    function automatic bus_op_t rsp_op(input logic [CAND_W-1:0] cand,
                                       input logic [RIDX_W-1:0] ridx);
        bus_op_t op;
        op.addr = ADDR_W'(ridx);
        if (cand == CAND_W'(0)) op.data = (ridx != '0) ? 8'hA2 : 8'h89;
        else                    op.data = (ridx != '0) ? 8'h20 : 8'h01;
        return op;
    endfunction

    function automatic int chip_shift(input logic [CAND_W-1:0] cand);
        return (cand == CAND_W'(0)) ? WIN_SHIFT : MIN_CHIP_SHIFT;
    endfunction

endpackage

// File: rtl/fprb_table.sv
module fprb_table
    import fprb_pkg::*;
(
    input  logic [CAND_W-1:0] cand,
    input  seq_e              seq,
    input  logic [IDX_W-1:0]  idx,
    input  logic [RIDX_W-1:0] ridx,
    input  logic [CHIP_W-1:0] chip,
    output bus_op_t           cmd,
    output logic              cmd_last,
    output bus_op_t           rsp,
    output logic              rsp_last,
    output logic              cand_last,
    output logic [ADDR_W-1:0] chip_base,
    output logic              chip_last
);

    int shift;
    int chips;

    always_comb begin
        shift     = chip_shift(cand);
        chips     = 1 << (WIN_SHIFT - shift);
        cmd       = cmd_op(cand, seq, idx);
        cmd_last  = (idx == cmd_last_idx(cand));
        rsp       = rsp_op(cand, ridx);
        rsp_last  = (ridx == RIDX_W'(RSP_LEN - 1));
        cand_last = (cand == CAND_W'(NUM_CAND - 1));
        chip_base = ADDR_W'(ADDR_W'(chip) << shift);
        chip_last = (chip == CHIP_W'(chips - 1));
    end

endmodule

// File: rtl/fprb_timer.sv
module fprb_timer #(
    parameter int WAIT_CYCLES = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    assign expired = run && (cnt == CNT_W'(WAIT_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (!expired) cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/flash_probe.sv
module flash_probe
    import fprb_pkg::*;
#(
    parameter int WAIT_CYCLES = 3750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              fl_we,
    output logic              fl_re,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic [7:0]        fl_rdata,
    output logic              busy,
    output logic              type_valid,
    output logic [CAND_W-1:0] type_code,
    output logic              probe_err
);

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_CMD_WR   = 3'd1,
        S_CMD_WAIT = 3'd2,
        S_RSP_RD   = 3'd3,
        S_RSP_CMP  = 3'd4
    } state_e;

    state_e            state;
    logic [CAND_W-1:0] cand;
    seq_e              seq;
    logic [IDX_W-1:0]  idx;
    logic [RIDX_W-1:0] ridx;
    logic [CHIP_W-1:0] chip;
    logic [CAND_W-1:0] type_q;
    logic              valid_q;
    logic              err_q;

    bus_op_t           cmd, rsp;
    logic              cmd_last, rsp_last, cand_last, chip_last;
    logic [ADDR_W-1:0] chip_base;
    logic              wait_done;

    fprb_table u_table (
        .cand      (cand),
        .seq       (seq),
        .idx       (idx),
        .ridx      (ridx),
        .chip      (chip),
        .cmd       (cmd),
        .cmd_last  (cmd_last),
        .rsp       (rsp),
        .rsp_last  (rsp_last),
        .cand_last (cand_last),
        .chip_base (chip_base),
        .chip_last (chip_last)
    );

    fprb_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_CMD_WAIT),
        .expired (wait_done)
    );

    // State register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cand    <= '0;
            seq     <= SEQ_ID;
            idx     <= '0;
            ridx    <= '0;
            chip    <= '0;
            type_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        valid_q <= 1'b0;
                        err_q   <= 1'b0;
                        cand    <= '0;
                        seq     <= SEQ_ID;
                        idx     <= '0;
                        chip    <= '0;
                        state   <= S_CMD_WR;
                    end
                end
                S_CMD_WR: state <= S_CMD_WAIT;
                S_CMD_WAIT: begin
                    if (wait_done) begin
                        if (!cmd_last) begin
                            idx   <= idx + IDX_W'(1);
                            state <= S_CMD_WR;
                        end else begin
                            idx <= '0;
                            unique case (seq)
                                SEQ_ID: begin
                                    ridx  <= '0;
                                    state <= S_RSP_RD;
                                end
                                SEQ_RST: begin
                                    seq   <= SEQ_RD;
                                    state <= S_CMD_WR;
                                end
                                default: begin
                                    if (chip_last) begin
                                        valid_q <= 1'b1;
                                        state   <= S_IDLE;
                                    end else begin
                                        chip  <= chip + CHIP_W'(1);
                                        seq   <= SEQ_RST;
                                        state <= S_CMD_WR;
                                    end
                                end
                            endcase
                        end
                    end
                end
                S_RSP_RD: state <= S_RSP_CMP;
                S_RSP_CMP: begin
                    if (fl_rdata == rsp.data) begin
                        if (rsp_last) begin
                            type_q <= cand;
                            chip   <= '0;
                            seq    <= SEQ_RST;
                            idx    <= '0;
                            state  <= S_CMD_WR;
                        end else begin
                            ridx  <= ridx + RIDX_W'(1);
                            state <= S_RSP_RD;
                        end
                    end else if (cand_last) begin
                        err_q <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        cand  <= cand + CAND_W'(1);
                        seq   <= SEQ_ID;
                        idx   <= '0;
                        state <= S_CMD_WR;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        fl_we      = (state == S_CMD_WR);
        fl_re      = (state == S_RSP_RD);
        fl_wdata   = cmd.data;
        if (state == S_RSP_RD)  fl_addr = rsp.addr;
        else if (seq == SEQ_ID) fl_addr = cmd.addr;
        else                    fl_addr = chip_base + cmd.addr;
        busy       = (state != S_IDLE);
        type_valid = valid_q;
        type_code  = type_q;
        probe_err  = err_q;
    end

endmodule

// File: rtl/flash_probe_chk.sv
module flash_probe_chk
    import fprb_pkg::*;
#(
    parameter int WAIT_CYCLES = 3750
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              fl_we,
    input logic              fl_re,
    input logic              busy,
    input logic              type_valid,
    input logic [CAND_W-1:0] type_code,
    input logic              probe_err
);

    localparam int GAP_W = $clog2(WAIT_CYCLES + 2);

    logic [GAP_W-1:0] gap;
    logic             pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap  <= '0;
            pend <= 1'b0;
        end else if (fl_we) begin
            gap  <= '0;
            pend <= 1'b1;
        end else if (pend && gap != GAP_W'(WAIT_CYCLES)) begin
            gap <= gap + GAP_W'(1);
        end
    end

    a_r5_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && gap < GAP_W'(WAIT_CYCLES)) |-> !(fl_we || fl_re));

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    a_r11_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we || fl_re) |-> busy);

    a_r8_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(type_valid && probe_err));

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (type_valid && !start) |=> (type_valid && $stable(type_code)));

    a_r1_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r1_flags_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!type_valid && !probe_err));

endmodule

bind flash_probe flash_probe_chk #(.WAIT_CYCLES(WAIT_CYCLES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .fl_we      (fl_we),
    .fl_re      (fl_re),
    .busy       (busy),
    .type_valid (type_valid),
    .type_code  (type_code),
    .probe_err  (probe_err)
);

// File: tb/flash_probe_tb_top.sv
module flash_probe_tb_top;
    import fprb_pkg::*;

    localparam int W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              fl_we, fl_re, busy, type_valid, probe_err;
    logic [ADDR_W-1:0] fl_addr;
    logic [7:0]        fl_wdata;
    logic [7:0]        fl_rdata;
    logic [CAND_W-1:0] type_code;

    always #2 clk = ~clk;

    flash_probe #(.WAIT_CYCLES(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .busy(busy), .type_valid(type_valid),
        .type_code(type_code), .probe_err(probe_err)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Flash model: kind 0 single-write part, 1 unlock part, 2 silent,
    // 3 single-write part with bad second byte, 4 unlock part with bad
    // second byte, 5 part answering both command sets.
    int          kind = 2;
    logic        model_rst = 1'b0;
    logic        id0, id1;
    int          ustage;
    logic [27:0] got_w[$];
    logic [19:0] got_r[$];
    logic [27:0] exp_w[$];
    logic [19:0] exp_r[$];
    logic        prev_w;
    int          last_w_cyc;
    int          gap_bad;

    function automatic logic [7:0] model_val(input logic [19:0] a);
        if (id0 && (a == 20'h0)) return 8'h89;
        if (id0 && (a == 20'h1)) return (kind == 3) ? 8'h00 : 8'hA2;
        if (id1 && (a == 20'h0)) return 8'h01;
        if (id1 && (a == 20'h1)) return (kind == 4) ? 8'h00 : 8'h20;
        return 8'hFF;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (model_rst) begin
            id0 <= 1'b0; id1 <= 1'b0; ustage <= 0; fl_rdata <= 8'hFF;
            got_w.delete(); got_r.delete();
            prev_w <= 1'b0; gap_bad <= 0;
        end else begin
            if (fl_we || fl_re) begin
                if (prev_w && (cyc - last_w_cyc != W + 1)) gap_bad <= gap_bad + 1;
                prev_w <= fl_we;
            end
            if (fl_we) begin
                last_w_cyc <= cyc;
                got_w.push_back({fl_addr, fl_wdata});
                if (fl_wdata == 8'h90 && (kind == 0 || kind == 3 || kind == 5)) id0 <= 1'b1;
                if (kind == 1 || kind == 4 || kind == 5) begin
                    if (fl_addr == 20'h05555 && fl_wdata == 8'hAA) ustage <= 1;
                    else if (ustage == 1 && fl_addr == 20'h02AAA && fl_wdata == 8'h55) ustage <= 2;
                    else if (ustage == 2 && fl_addr == 20'h05555 && fl_wdata == 8'h90) begin
                        id1 <= 1'b1; ustage <= 0;
                    end else ustage <= 0;
                end
            end
            if (fl_re) begin
                got_r.push_back(fl_addr);
                fl_rdata <= model_val(fl_addr);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected bus activity computed from the requirements (R2..R7)
    task automatic build_exp(input int k, output bit ok, output int typ);
        exp_w.delete(); exp_r.delete();
        ok = 0; typ = 0;
        exp_w.push_back({20'h00000, 8'h90});
        exp_r.push_back(20'h0);
        if (k == 0 || k == 5) begin exp_r.push_back(20'h1); ok = 1; typ = 0; end
        else if (k == 3) exp_r.push_back(20'h1);
        if (!ok) begin
            exp_w.push_back({20'h05555, 8'hAA});
            exp_w.push_back({20'h02AAA, 8'h55});
            exp_w.push_back({20'h05555, 8'h90});
            exp_r.push_back(20'h0);
            if (k == 1) begin exp_r.push_back(20'h1); ok = 1; typ = 1; end
            else if (k == 4) exp_r.push_back(20'h1);
        end
        if (ok && typ == 0) begin
            exp_w.push_back({20'h00000, 8'h50});
            exp_w.push_back({20'h00000, 8'hFF});
        end else if (ok) begin
            for (int c = 0; c < 8; c++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [19:0] b;
                    b = 20'(c) << 17;
                    exp_w.push_back({b + 20'h05555, 8'hAA});
                    exp_w.push_back({b + 20'h02AAA, 8'h55});
                    exp_w.push_back({b + 20'h05555, 8'hF0});
                end
            end
        end
    endtask

    task automatic run_probe(input int k, input bit extra, input int extra_dly);
        bit ok; int typ; int n; bit same; int bad_i;
        kind = k;
        @(negedge clk) model_rst = 1'b1;
        @(negedge clk) model_rst = 1'b0;
        build_exp(k, ok, typ);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy && !type_valid && !probe_err, "R1/R9", "busy/flags after start",
            {busy, type_valid, probe_err}, 3'b100);
        if (extra) begin
            repeat (extra_dly) @(negedge clk);
            if (busy) start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
        chk(n < 20000, "R1", "probe completion", n, 0);
        chk(type_valid == ok, ok ? "R9" : "R8", "type_valid", type_valid, ok);
        chk(probe_err == !ok, "R8", "probe_err", probe_err, !ok);
        if (ok) chk(type_code == typ, "R2", "type_code", type_code, typ);
        same = (got_w.size() == exp_w.size());
        bad_i = -1;
        for (int i = 0; same && i < exp_w.size(); i++)
            if (got_w[i] != exp_w[i]) begin same = 0; bad_i = i; end
        chk(same, ok ? "R7" : "R3/R4", "write list", bad_i < 0 ? got_w.size() : got_w[bad_i],
            bad_i < 0 ? exp_w.size() : exp_w[bad_i]);
        same = (got_r.size() == exp_r.size());
        for (int i = 0; same && i < exp_r.size(); i++)
            if (got_r[i] != exp_r[i]) same = 0;
        chk(same, "R6/R10", "read count", got_r.size(), exp_r.size());
        chk(gap_bad == 0, "R5", "settle gaps off", gap_bad, 0);
        n = 1 + ($urandom % 8);
        repeat (n) @(negedge clk);
        chk(type_valid == ok && probe_err == !ok && (!ok || type_code == typ), "R9",
            "result hold", {type_valid, probe_err}, {ok, !ok});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !type_valid && !probe_err && !fl_we && !fl_re, "R1", "reset state",
            {busy, type_valid, probe_err, fl_we, fl_re}, 0);
        rst_n = 1'b1;
        @(negedge clk) model_rst = 1'b0;
        run_probe(0, 0, 0);   // R3 single-write part
        run_probe(1, 0, 0);   // R4 unlock part
        run_probe(2, 0, 0);   // R8 nothing answers
        run_probe(3, 0, 0);   // R6 mismatch on second byte
        run_probe(4, 0, 0);   // R6 second candidate mismatch
        run_probe(5, 0, 0);   // R2 first match wins
        run_probe(1, 1, 3);   // R1 start ignored while busy
        for (int r = 0; r < 16; r++)
            run_probe($urandom % 6, 1'($urandom % 2), $urandom % 40);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule